// File: doc/BRIEF.md
# Single-Wire Bus Device-Side Write Receiver

This block sits on the device side of a single-wire, open-drain bus. It reads the bus level, already brought into the system clock domain as a plain input, and passes it through a two-flop synchronizer. The synchronized level drives three tasks. The first is to recognise a bus reset, meaning a long low level driven by the master. The second is to answer that reset with a presence pulse. The third is to decode the master's write slots into bits.

A slot opens on a falling edge of the bus. The block samples the bus once, at a fixed delay inside the device's valid window. A high sample gives a 1 and a low sample gives a 0. Any falling edge before the slot and its recovery time have run out is disregarded. Bits are collected least significant first. When the eighth bit arrives, the completed byte is presented with a one-cycle valid strobe.

The only drive the block has on the bus is a single pull-low enable. All durations are parameters counted in clock cycles. The defaults assume one cycle per microsecond.

Top module: `owire_slave_rx`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `pull_low_o` is 0, `byte_vld_o` is 0 and `byte_o` is 8'h00.
- R2: If the bus stays low for at least `RST_MIN_CYC` cycles and is then released, `pull_low_o` goes to 1 between `PRES_WAIT_CYC` and `PRES_WAIT_CYC`+5 cycles after the release. It then stays at 1 for exactly `PRES_LEN_CYC` cycles.
- R3: A low level shorter than `RST_MIN_CYC` cycles produces no presence pulse.
- R4: In a slot where the master releases the bus before the sample point, the decoded bit is 1. In a slot where the master holds the bus low past the sample point, the decoded bit is 0. The sample point is `SAMPLE_AT_CYC` cycles after the synchronized falling edge.
- R5: Decoded bits fill `byte_o` least significant bit first. The first bit of a byte lands in bit 0 and the eighth in bit 7. `byte_vld_o` is high for exactly one cycle per completed byte, in the cycle after the eighth bit is sampled.
- R6: A falling edge that arrives less than `SLOT_LEN_CYC` cycles after the start of a slot opens no new slot and adds no bit.
- R7: A detected bus reset discards any partly collected byte. The next byte is assembled from the first eight slots that follow the reset.
- R8: No bit is decoded while the presence sequence (wait and pulse) is in progress, so the device's own pull-low is not taken as a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_i | input | 1 | Sensed level of the open-drain bus (1 = released/high) |
| pull_low_o | output | 1 | When 1, the bus driver pulls the line low |
| byte_o | output | 8 | Last completed byte, bit 0 received first |
| byte_vld_o | output | 1 | One-cycle strobe marking a new value on `byte_o` |

## Verification
The assertions assume the master respects slot timing. Consecutive falling edges at the start of a byte's slots are spaced more than `SLOT_LEN_CYC` cycles apart, except for deliberate in-slot glitches. The bus is released before a presence sequence begins. The stimulus keeps to these rules by construction. Every slot lasts 72 cycles. A write-1 release falls between 2 and 11 cycles, and a write-0 low lasts 60 to 65 cycles. Glitches are placed only after the sample point and well before the slot closes. Reset pulses always end with the master releasing the bus before the device drives it.

// File: rtl/owsr_pkg.sv
// Shared types for the single-wire device-side receiver.
package owsr_pkg;
    // Phases of the presence answer that follows a bus reset
    typedef enum logic [1:0] {
        PR_IDLE  = 2'd0,
        PR_WAIT  = 2'd1,
        PR_DRIVE = 2'd2
    } pres_state_t;

    // Phases of the write-slot sampler
    typedef enum logic {
        SL_IDLE = 1'b0,
        SL_BUSY = 1'b1
    } slot_state_t;
endpackage

// File: rtl/owsr_sync.sv
// Two-flop synchronizer for the bus level plus edge detection.
// Assumes the bus idles high; reset values reflect that.
module owsr_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_s,
    output logic fall_o,
    output logic rise_o
);
    logic meta_q, sync_q, prev_q;

    // Synchronize the level and keep one cycle of history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= line_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign line_s = sync_q;
    assign fall_o = prev_q & ~sync_q;
    assign rise_o = ~prev_q & sync_q;
endmodule

// File: rtl/owsr_presence.sv
// Measures low time on the bus, flags a reset once the low time
// reaches RST_MIN, and after the release waits then pulls the bus
// low for PRES_LEN cycles. Assumes all counts are at least 2.
module owsr_presence
    import owsr_pkg::*;
#(
    parameter int RST_MIN   = 480,
    parameter int PRES_WAIT = 30,
    parameter int PRES_LEN  = 120,
    parameter int CW        = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_s,
    input  logic rise_i,
    output logic bus_rst_o,
    output logic busy_o,
    output logic pull_low_o
);
    logic [CW-1:0] low_cnt;
    logic [CW-1:0] tmr;
    logic          armed;
    pres_state_t   state;

    // Count consecutive low cycles, saturating at RST_MIN
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (line_s)
            low_cnt <= '0;
        else if (low_cnt < CW'(RST_MIN))
            low_cnt <= low_cnt + 1'b1;
    end

    // One-cycle reset strobe when the low time reaches the limit
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rst_o <= 1'b0;
        else
            bus_rst_o <= !line_s && (low_cnt == CW'(RST_MIN - 1));
    end

    // Remember that a reset was seen until presence starts
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (bus_rst_o)
            armed <= 1'b1;
        else if (state == PR_IDLE && rise_i)
            armed <= 1'b0;
    end

    // Presence sequencing: wait after release, then drive low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PR_IDLE;
            tmr   <= '0;
        end else begin
            case (state)
                PR_IDLE: begin
                    tmr <= '0;
                    if (armed && rise_i) state <= PR_WAIT;
                end
                PR_WAIT: begin
                    if (tmr == CW'(PRES_WAIT - 1)) begin
                        state <= PR_DRIVE;
                        tmr   <= '0;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                PR_DRIVE: begin
                    if (tmr == CW'(PRES_LEN - 1)) begin
                        state <= PR_IDLE;
                        tmr   <= '0;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                default: state <= PR_IDLE;
            endcase
        end
    end

    assign busy_o     = (state != PR_IDLE);
    assign pull_low_o = (state == PR_DRIVE);
endmodule

// File: rtl/owsr_slot.sv
// Opens a slot on a falling edge, samples the level SAMPLE_AT
// cycles later and stays closed to new edges for SLOT_LEN cycles.
// Assumes SAMPLE_AT < SLOT_LEN.
module owsr_slot
    import owsr_pkg::*;
#(
    parameter int SAMPLE_AT = 30,
    parameter int SLOT_LEN  = 61,
    parameter int CW        = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_s,
    input  logic fall_i,
    input  logic block_i,
    output logic bit_vld_o,
    output logic bit_val_o
);
    slot_state_t   state;
    logic [CW-1:0] cnt;

    // Slot timing: open on an edge, close after SLOT_LEN cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SL_IDLE;
            cnt   <= '0;
        end else if (state == SL_IDLE) begin
            cnt <= '0;
            if (fall_i && !block_i) state <= SL_BUSY;
        end else if (cnt == CW'(SLOT_LEN - 1)) begin
            state <= SL_IDLE;
            cnt   <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Take the single sample of the slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_vld_o <= 1'b0;
            bit_val_o <= 1'b0;
        end else begin
            bit_vld_o <= (state == SL_BUSY) && (cnt == CW'(SAMPLE_AT - 1));
            if ((state == SL_BUSY) && (cnt == CW'(SAMPLE_AT - 1)))
                bit_val_o <= line_s;
        end
    end
endmodule

// File: rtl/owsr_assemble.sv
// Shifts bits in LSB first and publishes each full word with a
// one-cycle strobe. A clear discards the partial word.
module owsr_assemble #(
    parameter int DATA_W = 8,
    parameter int BCW    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              bit_vld_i,
    input  logic              bit_val_i,
    output logic [DATA_W-1:0] word_o,
    output logic              word_vld_o,
    output logic [BCW-1:0]    bit_cnt_o
);
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] next_sh;

    assign next_sh = {bit_val_i, shreg[DATA_W-1:1]};

    // Shift register, bit counter and word publication
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg      <= '0;
            word_o     <= '0;
            word_vld_o <= 1'b0;
            bit_cnt_o  <= '0;
        end else begin
            word_vld_o <= 1'b0;
            if (clr_i) begin
                bit_cnt_o <= '0;
            end else if (bit_vld_i) begin
                shreg <= next_sh;
                if (bit_cnt_o == BCW'(DATA_W - 1)) begin
                    word_o     <= next_sh;
                    word_vld_o <= 1'b1;
                    bit_cnt_o  <= '0;
                end else begin
                    bit_cnt_o <= bit_cnt_o + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/owire_slave_rx.sv
// Device-side receiver for a single-wire open-drain bus: reset
// detection, presence answer and write-slot decoding into bytes.
// Assumes line_i reflects the wired-AND bus level including this
// block's own pull-low. Durations are in clock cycles.
module owire_slave_rx #(
    parameter int RST_MIN_CYC   = 480,
    parameter int PRES_WAIT_CYC = 30,
    parameter int PRES_LEN_CYC  = 120,
    parameter int SAMPLE_AT_CYC = 30,
    parameter int SLOT_LEN_CYC  = 61,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_i,
    output logic              pull_low_o,
    output logic [DATA_W-1:0] byte_o,
    output logic              byte_vld_o
);
    localparam int MAX_A  = (RST_MIN_CYC > PRES_LEN_CYC) ? RST_MIN_CYC : PRES_LEN_CYC;
    localparam int MAX_T  = (MAX_A > PRES_WAIT_CYC) ? MAX_A : PRES_WAIT_CYC;
    localparam int PCW    = $clog2(MAX_T + 1);
    localparam int SCW    = $clog2(SLOT_LEN_CYC + 1);
    localparam int BIT_CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic              line_s, fall, rise;
    logic              bus_rst, pres_busy;
    logic              bit_vld, bit_val;
    logic [BIT_CW-1:0] bit_cnt;

    owsr_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line_i),
        .line_s (line_s),
        .fall_o (fall),
        .rise_o (rise)
    );

    owsr_presence #(
        .RST_MIN   (RST_MIN_CYC),
        .PRES_WAIT (PRES_WAIT_CYC),
        .PRES_LEN  (PRES_LEN_CYC),
        .CW        (PCW)
    ) u_pres (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_s     (line_s),
        .rise_i     (rise),
        .bus_rst_o  (bus_rst),
        .busy_o     (pres_busy),
        .pull_low_o (pull_low_o)
    );

    owsr_slot #(
        .SAMPLE_AT (SAMPLE_AT_CYC),
        .SLOT_LEN  (SLOT_LEN_CYC),
        .CW        (SCW)
    ) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_s    (line_s),
        .fall_i    (fall),
        .block_i   (pres_busy),
        .bit_vld_o (bit_vld),
        .bit_val_o (bit_val)
    );

    owsr_assemble #(
        .DATA_W (DATA_W),
        .BCW    (BIT_CW)
    ) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (bus_rst),
        .bit_vld_i  (bit_vld),
        .bit_val_i  (bit_val),
        .word_o     (byte_o),
        .word_vld_o (byte_vld_o),
        .bit_cnt_o  (bit_cnt)
    );
endmodule

// File: rtl/owire_slave_rx_chk.sv
// Temporal checks on the receiver, attached by bind.
module owire_slave_rx_chk #(
    parameter int BW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pull_low_o,
    input logic          byte_vld_o,
    input logic          line_s,
    input logic          pres_busy,
    input logic          bit_vld,
    input logic          bus_rst,
    input logic [BW-1:0] bit_cnt
);
    // R5
    vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |=> !byte_vld_o);

    // R5
    vld_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |-> $past(bit_vld));

    // R8
    no_bit_in_presence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pres_busy |-> !bit_vld);

    // R7
    reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (bit_cnt == '0));

    // R2
    presence_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull_low_o) |-> line_s);
endmodule

bind owire_slave_rx owire_slave_rx_chk #(.BW(BIT_CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pull_low_o (pull_low_o),
    .byte_vld_o (byte_vld_o),
    .line_s     (line_s),
    .pres_busy  (pres_busy),
    .bit_vld    (bit_vld),
    .bus_rst    (bus_rst),
    .bit_cnt    (bit_cnt)
);

// File: tb/owire_slave_rx_tb.sv
module owire_slave_rx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RST_MIN    = 480;
    localparam int PWAIT      = 30;
    localparam int PLEN       = 120;
    localparam int SLOT       = 72;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_low = 1'b0;
    logic       pull_low;
    logic [7:0] byte_q;
    logic       byte_vld;
    wire        line = !(m_low || pull_low);

    int checks = 0;
    int errors = 0;
    logic [7:0] got_q[$];
    int  multi_pulse = 0;
    logic vld_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    owire_slave_rx u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_i     (line),
        .pull_low_o (pull_low),
        .byte_o     (byte_q),
        .byte_vld_o (byte_vld)
    );

    // Collect published bytes and watch strobe width
    always @(negedge clk) begin
        if (rst_n && byte_vld) got_q.push_back(byte_q);
        if (rst_n && byte_vld && vld_prev) multi_pulse++;
        vld_prev = byte_vld;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected word from bits in transmission order (first bit -> bit 0)
    function automatic logic [7:0] pack_first_low(input logic [7:0] tx_order);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = tx_order[i];
        return r;
    endfunction

    task automatic write_bit(input logic b, input bit glitch);
        int hold;
        hold = b ? 2 + int'($urandom % 10) : 60 + int'($urandom % 6);
        m_low = 1'b1;
        repeat (hold) @(negedge clk);
        m_low = 1'b0;
        if (glitch && b) begin
            repeat (40 - hold) @(negedge clk);
            m_low = 1'b1;
            repeat (2) @(negedge clk);
            m_low = 1'b0;
            repeat (SLOT - 42) @(negedge clk);
        end else begin
            repeat (SLOT - hold) @(negedge clk);
        end
    endtask

    task automatic send_byte(input logic [7:0] v, input bit glitch);
        logic [7:0] order;
        for (int i = 0; i < 8; i++) order[i] = v[i];
        for (int i = 0; i < 8; i++) write_bit(order[i], glitch);
        repeat (10) @(negedge clk);
    endtask

    task automatic expect_byte(input logic [7:0] v, input string req);
        check(got_q.size() == 1, req, got_q.size(), 1);
        if (got_q.size() >= 1)
            check(got_q[0] === pack_first_low(v), req, got_q[0], pack_first_low(v));
        got_q.delete();
    endtask

    task automatic bus_reset(input bit measure);
        int dly, width;
        m_low = 1'b1;
        repeat (RST_MIN + 20) @(negedge clk);
        m_low = 1'b0;
        dly = 0;
        while (!pull_low && dly < 200) begin @(negedge clk); dly++; end
        width = 0;
        while (pull_low && width < 400) begin @(negedge clk); width++; end
        if (measure) begin
            // R2 presence timing and width
            check(dly >= PWAIT && dly <= PWAIT + 5, "R2 delay", dly, PWAIT);
            check(width == PLEN, "R2 width", width, PLEN);
        end
        repeat (20) @(negedge clk);
        got_q.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seen;
        logic [7:0] v;
        void'($urandom(32'd20241));
        repeat (3) @(negedge clk);
        // R1 outputs during reset
        check(pull_low == 1'b0, "R1 pull", pull_low, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(byte_vld == 1'b0, "R1 vld", byte_vld, 0);
        check(byte_q == 8'h00, "R1 byte", byte_q, 0);

        // R3 short low gives no presence
        repeat (20) @(negedge clk);
        m_low = 1'b1;
        repeat (300) @(negedge clk);
        m_low = 1'b0;
        seen = 0;
        repeat (250) begin @(negedge clk); if (pull_low) seen++; end
        check(seen == 0, "R3 no presence", seen, 0);

        // R2 full reset with presence
        bus_reset(1'b1);

        // R4 R5 directed patterns
        send_byte(8'h01, 1'b0); expect_byte(8'h01, "R5 lsb first 01");
        send_byte(8'h80, 1'b0); expect_byte(8'h80, "R5 msb last 80");
        send_byte(8'hFF, 1'b0); expect_byte(8'hFF, "R4 all ones");
        send_byte(8'h00, 1'b0); expect_byte(8'h00, "R4 all zeros");

        // R4 R5 random bytes
        for (int k = 0; k < 8; k++) begin
            v = 8'($urandom);
            send_byte(v, 1'b0);
            expect_byte(v, "R4 random");
        end

        // R6 extra falling edges inside write-1 slots
        send_byte(8'hA5, 1'b1); expect_byte(8'hA5, "R6 glitch A5");
        send_byte(8'hFF, 1'b1); expect_byte(8'hFF, "R6 glitch FF");

        // R7 reset drops partial byte; R8 presence adds no bits
        write_bit(1'b1, 1'b0);
        write_bit(1'b0, 1'b0);
        write_bit(1'b1, 1'b0);
        bus_reset(1'b1);
        check(got_q.size() == 0, "R8 no byte from presence", got_q.size(), 0);
        send_byte(8'h3C, 1'b0); expect_byte(8'h3C, "R7 after reset");

        // R5 strobe width over the whole run
        check(multi_pulse == 0, "R5 strobe one cycle", multi_pulse, 0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule